// File: doc/BRIEF.md
# Dual-Read General-Purpose Register Bank with Zero/Stack-Pointer Alias

This block holds the integer architectural state of a 64-bit core: thirty-one ordinary registers at indices 0 to 30, plus a separate stack-pointer register reached through index 31. Whether index 31 means the stack pointer or a hard-wired zero is decided on every access by a context bit that travels with that access. The write port and each read port carry their own context bit.

Two read ports are combinational. Each returns the whole register, or only its low word (32 bits), halfword (16 bits) or byte (8 bits), padded to 64 bits with zeros or with copies of the top kept bit. The single write port is clocked. It takes either a full 64-bit value or a 32-bit value, and a 32-bit write clears the upper half of the destination.

Top module: `gpr_bank`

## Requirements
- R1: While `rst` is high at a rising clock edge, every ordinary register and the stack pointer become zero, so any read returns zero after that edge.
- R2: A write with `wr_en`=1 and `wr_wide`=1 replaces all 64 bits of the target, visible on the read ports after that rising edge.
- R3: A write with `wr_en`=1 and `wr_wide`=0 stores `wr_data[31:0]` in bits 31:0 of the target and clears bits 63:32, whatever the upper input bits hold.
- R4: A read of index 31 with its context bit (`ra_sp` or `rb_sp`) at 0 returns zero.
- R5: A write to index 31 with `wr_sp`=0 is discarded: neither the stack pointer nor any ordinary register changes.
- R6: With the context bit at 1, index 31 reads and writes the stack-pointer register, which is separate from registers 0 to 30.
- R7: Size select encoding is 00 byte, 01 halfword, 10 word, 11 full. With the signed bit at 0, a narrow read returns the low 8, 16 or 32 bits with all higher bits zero.
- R8: With the signed bit at 1, a narrow read fills the higher bits with bit 7, 15 or 31 of the register. A full read ignores the signed bit.
- R9: A read of a register being written in the same cycle returns the value held before the write edge; there is no bypass.
- R10: With `wr_en`=0 no register changes, whatever the other write inputs hold.
- R11: The two read ports act independently and may read different registers with different sizes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register index |
| wr_wide | input | 1 | 1 = 64-bit write, 0 = 32-bit write with upper half cleared |
| wr_sp | input | 1 | Write context: 1 = index 31 is the stack pointer, 0 = zero register |
| wr_data | input | 64 | Write value |
| ra_idx | input | 5 | Port A register index |
| ra_sp | input | 1 | Port A context for index 31 |
| ra_size | input | 2 | Port A size select |
| ra_signed | input | 1 | Port A sign-extend select |
| ra_data | output | 64 | Port A extended read value |
| rb_idx | input | 5 | Port B register index |
| rb_sp | input | 1 | Port B context for index 31 |
| rb_size | input | 2 | Port B size select |
| rb_signed | input | 1 | Port B sign-extend select |
| rb_data | output | 64 | Port B extended read value |

## Verification
Read results are combinational and due in the cycle their inputs are applied, while a write shows up on the read ports only after the next rising edge. The bench changes inputs on the falling edge and samples reads one time unit later. A write is checked only after the following rising edge, except in the same-cycle case, where the old value is expected before that edge. A bench model of the registers and the stack pointer, with the index-31 rules built in, gives the expected value for every read.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_FULL = 2'b11
  } rd_size_e;
endpackage

// File: rtl/gpr_extend.sv
module gpr_extend #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] raw,
  input  logic [1:0]      size,
  input  logic            sgn,
  output logic [XLEN-1:0] ext
);
  import gpr_pkg::*;
  localparam int WORD = XLEN / 2;

  always_comb begin
    case (rd_size_e'(size))
      SZ_BYTE: ext = {{(XLEN-8){sgn & raw[7]}}, raw[7:0]};
      SZ_HALF: ext = {{(XLEN-16){sgn & raw[15]}}, raw[15:0]};
      SZ_WORD: ext = {{(XLEN-WORD){sgn & raw[WORD-1]}}, raw[WORD-1:0]};
      default: ext = raw;
    endcase
  end
endmodule

// File: rtl/gpr_store.sv
module gpr_store #(
  parameter int XLEN = 64,
  parameter int NIDX = 32,
  parameter int NRD  = 2,
  localparam int AW   = $clog2(NIDX),
  localparam int WORD = XLEN / 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [AW-1:0]             widx,
  input  logic                      wwide,
  input  logic                      wsp,
  input  logic [XLEN-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0]    ridx,
  input  logic [NRD-1:0]            rsp,
  output logic [NRD-1:0][XLEN-1:0]  rraw
);
  localparam logic [AW-1:0] SP_IDX = AW'(NIDX - 1);

  logic [XLEN-1:0] regs [NIDX-1];
  logic [XLEN-1:0] sp_q;
  logic [XLEN-1:0] wval;

  // a narrow write is widened here, once, before it reaches storage
  assign wval = wwide ? wdata : {{(XLEN-WORD){1'b0}}, wdata[WORD-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NIDX-1; i++) regs[i] <= '0;
      sp_q <= '0;
    end else if (we) begin
      if (widx == SP_IDX) begin
        if (wsp) sp_q <= wval;
      end else begin
        regs[widx] <= wval;
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (ridx[p] == SP_IDX) rraw[p] = rsp[p] ? sp_q : '0;
      else                   rraw[p] = regs[ridx[p]];
    end
  end
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int XLEN = 64,
  parameter int NIDX = 32,
  localparam int AW  = $clog2(NIDX)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_idx,
  input  logic            wr_wide,
  input  logic            wr_sp,
  input  logic [XLEN-1:0] wr_data,
  input  logic [AW-1:0]   ra_idx,
  input  logic            ra_sp,
  input  logic [1:0]      ra_size,
  input  logic            ra_signed,
  output logic [XLEN-1:0] ra_data,
  input  logic [AW-1:0]   rb_idx,
  input  logic            rb_sp,
  input  logic [1:0]      rb_size,
  input  logic            rb_signed,
  output logic [XLEN-1:0] rb_data
);
  localparam int NRD = 2;

  logic [NRD-1:0][AW-1:0]   rd_idx;
  logic [NRD-1:0]           rd_sp;
  logic [NRD-1:0][1:0]      rd_size;
  logic [NRD-1:0]           rd_sgn;
  logic [NRD-1:0][XLEN-1:0] rd_raw;
  logic [NRD-1:0][XLEN-1:0] rd_out;

  assign rd_idx  = {rb_idx, ra_idx};
  assign rd_sp   = {rb_sp, ra_sp};
  assign rd_size = {rb_size, ra_size};
  assign rd_sgn  = {rb_signed, ra_signed};

  gpr_store #(.XLEN(XLEN), .NIDX(NIDX), .NRD(NRD)) store_i (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .widx  (wr_idx),
    .wwide (wr_wide),
    .wsp   (wr_sp),
    .wdata (wr_data),
    .ridx  (rd_idx),
    .rsp   (rd_sp),
    .rraw  (rd_raw)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_ext
    gpr_extend #(.XLEN(XLEN)) ext_i (
      .raw  (rd_raw[p]),
      .size (rd_size[p]),
      .sgn  (rd_sgn[p]),
      .ext  (rd_out[p])
    );
  end

  assign ra_data = rd_out[0];
  assign rb_data = rd_out[1];
endmodule

// File: rtl/gpr_bank_chk.sv
module gpr_bank_chk #(
  parameter int XLEN = 64,
  parameter int NIDX = 32,
  localparam int AW   = $clog2(NIDX),
  localparam int WORD = XLEN / 2
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [AW-1:0]   wr_idx,
  input logic            wr_wide,
  input logic            wr_sp,
  input logic [XLEN-1:0] wr_data,
  input logic [AW-1:0]   ra_idx,
  input logic            ra_sp,
  input logic [1:0]      ra_size,
  input logic            ra_signed,
  input logic [XLEN-1:0] ra_data,
  input logic [AW-1:0]   rb_idx,
  input logic            rb_sp,
  input logic [1:0]      rb_size,
  input logic            rb_signed,
  input logic [XLEN-1:0] rb_data
);
  localparam logic [AW-1:0] SP_IDX = AW'(NIDX - 1);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (ra_data == '0 && rb_data == '0));

  a_r4_zero_alias_a: assert property (@(posedge clk) disable iff (rst)
    (ra_idx == SP_IDX && !ra_sp) |-> ra_data == '0);

  a_r4_zero_alias_b: assert property (@(posedge clk) disable iff (rst)
    (rb_idx == SP_IDX && !rb_sp) |-> rb_data == '0);

  a_r2_full_write_seen: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(wr_en) && $past(wr_wide)
     && ($past(wr_idx) != SP_IDX || $past(wr_sp))
     && ra_idx == $past(wr_idx) && (ra_idx != SP_IDX || ra_sp)
     && ra_size == 2'b11)
    |-> ra_data == $past(wr_data));

  a_r3_upper_cleared: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(wr_en) && !$past(wr_wide)
     && ($past(wr_idx) != SP_IDX || $past(wr_sp))
     && ra_idx == $past(wr_idx) && (ra_idx != SP_IDX || ra_sp)
     && ra_size == 2'b11)
    |-> ra_data == {{(XLEN-WORD){1'b0}}, $past(wr_data[WORD-1:0])});

  a_r7_byte_zero_ext: assert property (@(posedge clk) disable iff (rst)
    (ra_size == 2'b00 && !ra_signed) |-> ra_data[XLEN-1:8] == '0);

  a_r8_byte_sign_ext: assert property (@(posedge clk) disable iff (rst)
    (rb_size == 2'b00 && rb_signed) |-> rb_data[XLEN-1:8] == {(XLEN-8){rb_data[7]}});
endmodule

bind gpr_bank gpr_bank_chk #(.XLEN(XLEN), .NIDX(NIDX)) chk_i (.*);

// File: tb/gpr_bank_tb.sv
module gpr_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NROW = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_wide = 1'b0, wr_sp = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic [4:0]  ra_idx = '0, rb_idx = '0;
  logic        ra_sp = 1'b0, rb_sp = 1'b0, ra_signed = 1'b0, rb_signed = 1'b0;
  logic [1:0]  ra_size = 2'b11, rb_size = 2'b11;
  logic [63:0] ra_data, rb_data;

  int checks = 0;
  int errors = 0;

  logic [63:0] m_gpr [31];
  logic [63:0] m_sp;

  // {en, wide, ctx, idx[4:0], data[63:0]}
  localparam logic [71:0] TBL [NROW] = '{
    {1'b1, 1'b1, 1'b0, 5'd3,  64'h8000_0000_0000_00F1},
    {1'b1, 1'b0, 1'b0, 5'd3,  64'hFFFF_FFFF_8765_4321},
    {1'b1, 1'b1, 1'b0, 5'd31, 64'hAAAA_AAAA_AAAA_AAAA},
    {1'b1, 1'b1, 1'b1, 5'd31, 64'h0000_7FFF_FFFF_FF80},
    {1'b1, 1'b0, 1'b1, 5'd31, 64'hDEAD_BEEF_0000_8001},
    {1'b0, 1'b1, 1'b0, 5'd7,  64'h5555_5555_5555_5555},
    {1'b1, 1'b1, 1'b0, 5'd30, 64'hFFFF_FFFF_FFFF_FF7F},
    {1'b1, 1'b1, 1'b0, 5'd0,  64'h0123_4567_89AB_CDEF},
    {1'b1, 1'b0, 1'b0, 5'd31, 64'h0000_0000_0000_0001},
    {1'b1, 1'b1, 1'b0, 5'd30, 64'h0000_0000_0000_0080}
  };

  gpr_bank dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] ext(input logic [63:0] v, input logic [1:0] sz, input logic s);
    case (sz)
      2'b00:   return s ? {{56{v[7]}}, v[7:0]}   : {56'd0, v[7:0]};
      2'b01:   return s ? {{48{v[15]}}, v[15:0]} : {48'd0, v[15:0]};
      2'b10:   return s ? {{32{v[31]}}, v[31:0]} : {32'd0, v[31:0]};
      default: return v;
    endcase
  endfunction

  function automatic logic [63:0] mread(input logic [4:0] idx, input logic ctx);
    if (idx == 5'd31) return ctx ? m_sp : 64'd0;
    return m_gpr[idx];
  endfunction

  function automatic string rtag(input logic [4:0] idx, input logic ctx,
                                 input logic [1:0] sz, input logic s);
    if (idx == 5'd31 && !ctx) return "R4";
    if (sz == 2'b11) return (idx == 5'd31) ? "R6" : "R2";
    return s ? "R8" : "R7";
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_write(input logic en, input logic wide, input logic ctx,
                             input logic [4:0] idx, input logic [63:0] d);
    logic [63:0] v;
    v = wide ? d : {32'd0, d[31:0]};
    if (en) begin
      if (idx == 5'd31) begin
        if (ctx) m_sp = v;
      end else begin
        m_gpr[idx] = v;
      end
    end
  endtask

  // drive on falling edge, commit at rising edge, release on next falling edge
  task automatic do_write(input logic en, input logic wide, input logic ctx,
                          input logic [4:0] idx, input logic [63:0] d);
    @(negedge clk);
    wr_en = en; wr_wide = wide; wr_sp = ctx; wr_idx = idx; wr_data = d;
    @(posedge clk);
    model_write(en, wide, ctx, idx, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 31; i++) m_gpr[i] = '0;
    m_sp = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state on every index in both contexts
    for (int i = 0; i < 32; i++) begin
      for (int c = 0; c < 2; c++) begin
        ra_idx = 5'(i); ra_sp = c[0]; ra_size = 2'b11; ra_signed = 1'b0;
        #1 check("R1 reset state", ra_data, 64'd0);
      end
    end

    // table walk: write, then read the target at all sizes on both ports
    for (int r = 0; r < NROW; r++) begin
      string wtag;
      logic [4:0] ti;
      ti = TBL[r][68:64];
      if (!TBL[r][71])                      wtag = "R10";
      else if (ti == 5'd31 && !TBL[r][69])  wtag = "R5";
      else if (!TBL[r][70])                 wtag = "R3";
      else                                  wtag = "R2";
      do_write(TBL[r][71], TBL[r][70], TBL[r][69], ti, TBL[r][63:0]);
      for (int sz = 0; sz < 4; sz++) begin
        for (int sg = 0; sg < 2; sg++) begin
          for (int c = 0; c < 2; c++) begin
            ra_idx = ti; ra_sp = c[0]; ra_size = 2'(sz); ra_signed = sg[0];
            rb_idx = ti; rb_sp = c[0]; rb_size = 2'(3 - sz); rb_signed = ~sg[0];
            #1;
            check($sformatf("%s/%s port A row %0d", wtag, rtag(ti, c[0], 2'(sz), sg[0]), r),
                  ra_data, ext(mread(ti, c[0]), 2'(sz), sg[0]));
            check($sformatf("%s/%s port B row %0d", wtag, rtag(ti, c[0], 2'(3 - sz), ~sg[0]), r),
                  rb_data, ext(mread(ti, c[0]), 2'(3 - sz), ~sg[0]));
          end
        end
      end
    end

    // R9: same-cycle read sees the old value, new value after the edge
    @(negedge clk);
    wr_en = 1'b1; wr_wide = 1'b1; wr_sp = 1'b0; wr_idx = 5'd12; wr_data = 64'hC0FF_EE00_1234_9876;
    ra_idx = 5'd12; ra_sp = 1'b0; ra_size = 2'b11; ra_signed = 1'b0;
    #1 check("R9 old value in write cycle", ra_data, 64'd0);
    @(posedge clk);
    model_write(1'b1, 1'b1, 1'b0, 5'd12, 64'hC0FF_EE00_1234_9876);
    @(negedge clk);
    wr_en = 1'b0;
    #1 check("R9 new value after edge", ra_data, 64'hC0FF_EE00_1234_9876);

    // R11: ports read different registers with different sizes at once
    ra_idx = 5'd12; ra_size = 2'b01; ra_signed = 1'b1;
    rb_idx = 5'd3;  rb_sp = 1'b0; rb_size = 2'b10; rb_signed = 1'b1;
    #1;
    check("R11 port A independent", ra_data, 64'hFFFF_FFFF_FFFF_9876);
    check("R11 port B independent", rb_data, 64'hFFFF_FFFF_8765_4321);

    // R6: stack pointer is distinct from register 30
    ra_idx = 5'd31; ra_sp = 1'b1; ra_size = 2'b11;
    rb_idx = 5'd30; rb_size = 2'b11;
    #1;
    check("R6 stack pointer kept", ra_data, 64'h0000_0000_0000_8001);
    check("R6 register 30 separate", rb_data, 64'h0000_0000_0000_0080);

    // R1: reset again clears everything
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    for (int i = 0; i < 31; i++) m_gpr[i] = '0;
    m_sp = '0;
    @(negedge clk);
    rst = 1'b0;
    ra_idx = 5'd31; ra_sp = 1'b1; rb_idx = 5'd3; rb_size = 2'b11;
    #1;
    check("R1 stack pointer cleared", ra_data, 64'd0);
    check("R1 register cleared", rb_data, 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule